// File: doc/BRIEF.md
# Serial EEPROM Command Front End

This block is the slave-side serial front end of a small serial EEPROM model with 2048 bytes of storage and an 11-bit byte address. It runs on a fast system clock and oversamples the SPI pins: chip select, serial clock, serial input and a hold input. It assembles the command byte and the 16-bit address field, decodes six commands, and drives the serial output together with an output enable. The output enable stands in for a tri-state pin.

For reads, the block keeps its own address pointer. It fetches bytes from a synchronous memory port that returns data one system clock after the address, and it steps through memory as long as the host keeps clocking. For writes, it passes each received data byte out with a one-cycle strobe. When chip select rises, it reports either a commit or a cancel, based on the exact bit position at which chip select was released.

Write protection, the page buffer and the write timer sit in neighbouring blocks. Those blocks consume the strobes and drive the `busy` input back into this block.

Top module: `spi_eeprom_front`

## Requirements
- R1: Serial input is sampled on rising SCK edges and serial output changes on falling SCK edges, both most significant bit first. SCK idle low and SCK idle high are both accepted.
- R2: The command byte is decoded as follows: 06h enable-write, 04h disable-write, 03h read, 02h write, 05h read-status, 01h write-status. Any other value causes no strobe and no output drive for the rest of the frame.
- R3: If chip select falls while SCK is high, that level does not count as a rising edge. The first bit is taken on the next SCK rise.
- R4: `wrenStb` or `wrdiStb` pulses for one cycle after the 8th rising edge of an 06h or 04h frame. Further clocks in the same frame cause no second pulse.
- R5: A read uses the low 11 bits of its 16-bit address field. The first data bit appears after the falling edge that follows the 24th rising edge. The address then advances by one per byte and wraps from 7FFh to 0.
- R6: Hold starts only on a falling `holdN` while SCK is low, and it ends only on a rising `holdN` while SCK is low. While held, SCK and MOSI are ignored and `misoOe` is 0. After release, the transfer continues at the bit where it stopped. A `holdN` fall while SCK is high has no effect.
- R7: Raising chip select during hold abandons the frame. A write or write-status frame reports `cancelStb`, never `commitStb`.
- R8: In a write frame, each complete data byte gives `dataByteStb` with `dataByte`, and `cmdAddr` holds the low 11 address bits. On chip select rise, `commitStb` pulses (with `commitStatus` 0) if at least one data byte was received and no partial byte is pending. Otherwise `cancelStb` pulses.
- R9: A write-status frame commits (with `commitStatus` 1) only when chip select rises right after exactly one data byte. Any other release point gives `cancelStb`.
- R10: While `busy` is high at the end of the command byte, every command except read-status is ignored.
- R11: While chip select is high, `misoOe` is 0 and the bit and byte positions are cleared, so the next frame starts a fresh command byte.
- R12: Read-status shifts out `statusIn` repeatedly for as long as the host clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCK |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data in |
| holdN | input | 1 | Hold request, active low |
| busy | input | 1 | Internal write in progress |
| statusIn | input | 8 | Status byte returned by read-status |
| memRdData | input | 8 | Memory read data, one clock after memAddr |
| miso | output | 1 | Serial data out |
| misoOe | output | 1 | Output enable for miso |
| memAddr | output | 11 | Read address to memory |
| wrenStb | output | 1 | Enable-write command accepted |
| wrdiStb | output | 1 | Disable-write command accepted |
| dataByteStb | output | 1 | Data byte received |
| dataByte | output | 8 | Received data byte |
| cmdAddr | output | 11 | Address of the current write command |
| commitStb | output | 1 | Start the internal write |
| cancelStb | output | 1 | Discard the pending write |
| commitStatus | output | 1 | Commit targets the status register |

## Verification
The bench reads across the top of memory. A design that forgets to wrap would fetch past 7FFh, and one that keeps the upper address-field bits would read the wrong bytes.

It pauses with hold in both the address phase and the data phase while toggling SCK with junk on MOSI. A design that counts clocks during hold, or that keeps driving output, would shift the stream or leave `misoOe` high.

Chip select is released at many points:
- on a byte boundary;
- in mid-byte;
- after only the address;
- after two status bytes;
- inside a hold.

A design with a loose commit window would start writes that should be cancelled. A frame with SCK idle high checks that the stale high level at chip-select fall is not counted as a bit, and a busy phase checks that only read-status still gets through.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 11;
  localparam int AFIELD_W = 16;
  localparam int SYNC_W   = 4;

  localparam logic [DATA_W-1:0] OP_WREN = 8'h06;
  localparam logic [DATA_W-1:0] OP_WRDI = 8'h04;
  localparam logic [DATA_W-1:0] OP_READ = 8'h03;
  localparam logic [DATA_W-1:0] OP_WRITE = 8'h02;
  localparam logic [DATA_W-1:0] OP_RDSR = 8'h05;
  localparam logic [DATA_W-1:0] OP_WRSR = 8'h01;

  typedef enum logic [2:0] {
    CMD_IDLE, CMD_READ, CMD_WRITE, CMD_RDSR, CMD_WRSR, CMD_DONE
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic sample;      // accepted rising SCK: shift MOSI in
    logic latchHi;     // upper address byte complete
    logic latchLo;     // lower address byte complete (write)
    logic latchByte;   // data byte complete
    logic rdLoad;      // load read pointer from address field
    logic rdInc;       // advance read pointer
    logic outLoadMem;  // load output shifter from memory
    logic outLoadStat; // load output shifter from status
    logic outShift;    // next output bit
    logic clear;       // chip select high
  } dp_ctl_t;
endpackage

// File: rtl/spi_eeprom_sync.sv
module spi_eeprom_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
  import spi_eeprom_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sckS,
  input  logic          csS,
  input  logic          holdS,
  input  logic          busy,
  input  logic [DW-1:0] curByte,
  output dp_ctl_t       ctl,
  output logic          misoOe,
  output logic          wrenStb,
  output logic          wrdiStb,
  output logic          dataByteStb,
  output logic          commitStb,
  output logic          cancelStb,
  output logic          commitStatus
);
  localparam int BIT_W = $clog2(DW);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DW - 1);
  localparam logic [2:0] BYTE_SAT = 3'd4;

  logic sckP, holdP, csP;
  logic holdQ, drvQ;
  logic [BIT_W-1:0] bitIdx;
  logic [2:0] byteNum;
  cmd_e cmdQ, cmdDec;

  wire csActive  = ~csS;
  wire rise      = csActive & ~holdQ & sckS & ~sckP;
  wire fall      = csActive & ~holdQ & ~sckS & sckP;
  wire byteEnd   = rise & (bitIdx == LAST_BIT);
  wire csRise    = csS & ~csP;
  wire holdEnter = csActive & ~holdQ & holdP & ~holdS & ~sckS;
  wire holdLeave = holdQ & ~holdP & holdS & ~sckS;
  wire isRead    = (cmdQ == CMD_READ);
  wire isWrite   = (cmdQ == CMD_WRITE);
  wire isWrsr    = (cmdQ == CMD_WRSR);
  wire okWrite   = isWrite & ~holdQ & (bitIdx == '0) & (byteNum == BYTE_SAT);
  wire okWrsr    = isWrsr & ~holdQ & (bitIdx == '0) & (byteNum == 3'd2);
  wire opByte    = byteEnd & (byteNum == 3'd0);

  always_comb begin
    unique case (curByte)
      OP_READ:  cmdDec = CMD_READ;
      OP_WRITE: cmdDec = CMD_WRITE;
      OP_RDSR:  cmdDec = CMD_RDSR;
      OP_WRSR:  cmdDec = CMD_WRSR;
      default:  cmdDec = CMD_DONE;
    endcase
    if (busy && curByte != OP_RDSR) cmdDec = CMD_DONE;
  end

  always_comb begin
    ctl             = '0;
    ctl.sample      = rise;
    ctl.latchHi     = byteEnd & (isRead | isWrite) & (byteNum == 3'd1);
    ctl.latchLo     = byteEnd & isWrite & (byteNum == 3'd2);
    ctl.rdLoad      = byteEnd & isRead & (byteNum == 3'd2);
    ctl.rdInc       = byteEnd & isRead & (byteNum >= 3'd3);
    ctl.latchByte   = byteEnd & ((isWrite & (byteNum >= 3'd3)) | (isWrsr & (byteNum >= 3'd1)));
    ctl.outLoadMem  = fall & (bitIdx == '0) & isRead & (byteNum >= 3'd3);
    ctl.outLoadStat = fall & (bitIdx == '0) & (cmdQ == CMD_RDSR) & (byteNum >= 3'd1);
    ctl.outShift    = fall & drvQ & (bitIdx != '0);
    ctl.clear       = ~csActive;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckP <= 1'b0; holdP <= 1'b1; csP <= 1'b1;
      holdQ <= 1'b0; drvQ <= 1'b0;
      bitIdx <= '0; byteNum <= '0; cmdQ <= CMD_IDLE;
      wrenStb <= 1'b0; wrdiStb <= 1'b0; dataByteStb <= 1'b0;
      commitStb <= 1'b0; cancelStb <= 1'b0; commitStatus <= 1'b0;
    end else begin
      sckP  <= sckS;
      holdP <= holdS;
      csP   <= csS;
      wrenStb     <= opByte & ~busy & (curByte == OP_WREN);
      wrdiStb     <= opByte & ~busy & (curByte == OP_WRDI);
      dataByteStb <= ctl.latchByte;
      commitStb   <= csRise & (okWrite | okWrsr);
      cancelStb   <= csRise & (isWrite | isWrsr) & ~(okWrite | okWrsr);
      if (csRise & (okWrite | okWrsr)) commitStatus <= okWrsr;
      if (!csActive) begin
        holdQ <= 1'b0; drvQ <= 1'b0;
        bitIdx <= '0; byteNum <= '0; cmdQ <= CMD_IDLE;
      end else begin
        if (holdEnter) holdQ <= 1'b1;
        else if (holdLeave) holdQ <= 1'b0;
        if (rise) begin
          bitIdx <= bitIdx + 1'b1;
          if (byteEnd && byteNum != BYTE_SAT) byteNum <= byteNum + 1'b1;
        end
        if (opByte) cmdQ <= cmdDec;
        if (ctl.outLoadMem | ctl.outLoadStat) drvQ <= 1'b1;
      end
    end
  end

  assign misoOe = drvQ & ~holdQ;
endmodule

// File: rtl/spi_eeprom_dp.sv
module spi_eeprom_dp
  import spi_eeprom_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          mosiS,
  input  dp_ctl_t       ctl,
  input  logic [DW-1:0] memRdData,
  input  logic [DW-1:0] statusIn,
  output logic [DW-1:0] curByte,
  output logic          miso,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] dataByte,
  output logic [AW-1:0] cmdAddr
);
  localparam int HI_W = AW - DW;

  logic [DW-2:0]   inSh;
  logic [DW-2:0]   outSh;
  logic [HI_W-1:0] addrHi;
  logic [DW-1:0]   addrLo;
  logic [AW-1:0]   rdAddr;

  assign curByte = {inSh, mosiS};
  assign cmdAddr = {addrHi, addrLo};
  assign memAddr = rdAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSh <= '0; outSh <= '0; addrHi <= '0; addrLo <= '0;
      rdAddr <= '0; dataByte <= '0; miso <= 1'b0;
    end else begin
      if (ctl.sample)    inSh <= curByte[DW-2:0];
      if (ctl.latchHi)   addrHi <= curByte[HI_W-1:0];
      if (ctl.latchLo)   addrLo <= curByte;
      if (ctl.latchByte) dataByte <= curByte;
      if (ctl.rdLoad)      rdAddr <= {addrHi, curByte};
      else if (ctl.rdInc)  rdAddr <= rdAddr + 1'b1;
      if (ctl.clear) begin
        miso <= 1'b0;
      end else if (ctl.outLoadMem) begin
        miso <= memRdData[DW-1]; outSh <= memRdData[DW-2:0];
      end else if (ctl.outLoadStat) begin
        miso <= statusIn[DW-1]; outSh <= statusIn[DW-2:0];
      end else if (ctl.outShift) begin
        miso <= outSh[DW-2]; outSh <= {outSh[DW-3:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_eeprom_front.sv
module spi_eeprom_front
  import spi_eeprom_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csN,
  input  logic          sck,
  input  logic          mosi,
  input  logic          holdN,
  input  logic          busy,
  input  logic [DW-1:0] statusIn,
  input  logic [DW-1:0] memRdData,
  output logic          miso,
  output logic          misoOe,
  output logic [AW-1:0] memAddr,
  output logic          wrenStb,
  output logic          wrdiStb,
  output logic          dataByteStb,
  output logic [DW-1:0] dataByte,
  output logic [AW-1:0] cmdAddr,
  output logic          commitStb,
  output logic          cancelStb,
  output logic          commitStatus
);
  logic [SYNC_W-1:0] pinsS;
  logic [DW-1:0] curByte;
  dp_ctl_t ctl;

  spi_eeprom_sync #(.W(SYNC_W), .RST_VAL(4'b1100)) sync_i (
    .clk(clk), .rstN(rstN), .d({csN, holdN, sck, mosi}), .q(pinsS));

  spi_eeprom_ctrl #(.DW(DW)) ctrl_i (
    .clk(clk), .rstN(rstN), .sckS(pinsS[1]), .csS(pinsS[3]), .holdS(pinsS[2]),
    .busy(busy), .curByte(curByte), .ctl(ctl), .misoOe(misoOe),
    .wrenStb(wrenStb), .wrdiStb(wrdiStb), .dataByteStb(dataByteStb),
    .commitStb(commitStb), .cancelStb(cancelStb), .commitStatus(commitStatus));

  spi_eeprom_dp #(.DW(DW), .AW(AW)) dp_i (
    .clk(clk), .rstN(rstN), .mosiS(pinsS[0]), .ctl(ctl), .memRdData(memRdData),
    .statusIn(statusIn), .curByte(curByte), .miso(miso), .memAddr(memAddr),
    .dataByte(dataByte), .cmdAddr(cmdAddr));
endmodule

// File: rtl/spi_eeprom_front_chk.sv
module spi_eeprom_front_chk (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic misoOe,
  input logic wrenStb,
  input logic wrdiStb,
  input logic dataByteStb,
  input logic commitStb,
  input logic cancelStb
);
  logic [2:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 1'b1;
  end
  wire warm = (sinceRst >= 3'd4);

  // R11: three cycles of deselect silence the output
  assert_oe_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(csN, 1) && $past(csN, 2) && $past(csN, 3)) |-> !misoOe);
  // R8: no byte strobe while deselected
  assert_byte_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(csN, 1) && $past(csN, 2) && $past(csN, 3)) |-> !dataByteStb);
  // R7: commit and cancel exclusive
  assert_commit_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({commitStb, cancelStb}));
  // R8: commit and cancel only after chip select went high
  assert_commit_cs_R8: assert property (@(posedge clk) disable iff (!rstN)
    (warm && (commitStb || cancelStb)) |-> $past(csN, 3));
  // R4: single-cycle command strobes
  assert_wren_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrenStb |=> !wrenStb);
  // R2: one decoded command per frame
  assert_wr_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(wrenStb && wrdiStb));
endmodule

bind spi_eeprom_front spi_eeprom_front_chk chk_i (
  .clk(clk), .rstN(rstN), .csN(csN), .misoOe(misoOe), .wrenStb(wrenStb),
  .wrdiStb(wrdiStb), .dataByteStb(dataByteStb), .commitStb(commitStb),
  .cancelStb(cancelStb));

// File: tb/spi_eeprom_front_tb.sv
`timescale 1ns/1ps
module spi_eeprom_front_tb_top;
  localparam int H = 6;

  logic clk = 0, rstN = 0;
  logic csN = 1, sck = 0, mosi = 0, holdN = 1, busy = 0;
  logic [7:0] statusIn = 8'h00, memRdData;
  logic miso, misoOe, wrenStb, wrdiStb, dataByteStb, commitStb, cancelStb, commitStatus;
  logic [10:0] memAddr, cmdAddr;
  logic [7:0] dataByte;

  int runCnt = 0, failCnt = 0;
  int wrenCnt = 0, wrdiCnt = 0, byteCnt = 0, commitCnt = 0, cancelCnt = 0;
  logic [7:0] lastByte = 0;
  logic lastSt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_eeprom_front dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi), .holdN(holdN),
    .busy(busy), .statusIn(statusIn), .memRdData(memRdData), .miso(miso),
    .misoOe(misoOe), .memAddr(memAddr), .wrenStb(wrenStb), .wrdiStb(wrdiStb),
    .dataByteStb(dataByteStb), .dataByte(dataByte), .cmdAddr(cmdAddr),
    .commitStb(commitStb), .cancelStb(cancelStb), .commitStatus(commitStatus));

  function automatic logic [7:0] memFn(input logic [10:0] a);
    return a[7:0] ^ {a[10:8], 5'b10101};
  endfunction

  always @(posedge clk) begin
    memRdData <= memFn(memAddr);
    if (rstN) begin
      if (wrenStb) wrenCnt++;
      if (wrdiStb) wrdiCnt++;
      if (dataByteStb) begin byteCnt++; lastByte = dataByte; end
      if (commitStb) begin commitCnt++; lastSt = commitStatus; end
      if (cancelStb) cancelCnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    runCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitH();
    repeat (H) @(negedge clk);
  endtask

  task automatic spiBit(input logic b, output logic r, output logic o);
    sck = 0; mosi = b; waitH();
    r = miso; o = misoOe;
    sck = 1; waitH();
  endtask

  task automatic sendBits(input logic [15:0] v, input int n, output logic [15:0] rx, output logic oeAll);
    rx = '0; oeAll = 1;
    for (int i = n - 1; i >= 0; i--) begin
      logic r, o;
      spiBit(v[i], r, o);
      rx[i] = r; oeAll &= o;
    end
  endtask

  task automatic csLow();
    csN = 0; waitH();
  endtask

  task automatic csHigh();
    sck = 0; waitH(); csN = 1; waitH(); waitH();
  endtask

  task automatic holdPause(input int garbage, output logic oeHeld);
    sck = 0; waitH(); holdN = 0; waitH();
    oeHeld = misoOe;
    for (int i = 0; i < garbage; i++) begin
      mosi = ~mosi; sck = 1; waitH(); sck = 0; waitH();
    end
    holdN = 1; waitH();
  endtask

  task automatic t_reset();
    check(misoOe == 0, "R11 reset oe", misoOe, 0);
    check(wrenCnt + wrdiCnt + byteCnt + commitCnt + cancelCnt == 0, "R11 reset strobes",
          wrenCnt + byteCnt, 0);
  endtask

  task automatic t_wrenWrdi();
    logic [15:0] rx; logic oe;
    csLow(); sendBits(16'h06, 8, rx, oe); sendBits(16'h0F, 5, rx, oe); csHigh();
    check(wrenCnt == 1, "R4 wren once with extra clocks", wrenCnt, 1);
    csLow(); sendBits(16'h04, 8, rx, oe); csHigh();
    check(wrdiCnt == 1 && wrenCnt == 1, "R2 wrdi decode", wrdiCnt, 1);
  endtask

  task automatic t_mode3();
    logic [15:0] rx; logic oe;
    sck = 1; waitH(); csN = 0; waitH();
    sendBits(16'h06, 8, rx, oe);
    csN = 1; waitH(); waitH(); sck = 0; waitH();
    check(wrenCnt == 2, "R3 cs fall with sck high not sampled", wrenCnt, 2);
  endtask

  task automatic t_unknown();
    logic [15:0] rx; logic oe;
    csLow(); sendBits(16'hFF, 8, rx, oe); sendBits(16'h0000, 16, rx, oe);
    check(oe == 0, "R2 unknown opcode no drive", oe, 0);
    csHigh();
    check(wrenCnt == 2 && wrdiCnt == 1 && byteCnt == 0 && cancelCnt == 0,
          "R2 unknown opcode no strobe", byteCnt, 0);
  endtask

  task automatic t_readWrap();
    logic [15:0] rx; logic oe;
    logic [10:0] a = 11'h7FE;
    csLow(); sendBits(16'h03, 8, rx, oe); sendBits(16'hF7FE, 16, rx, oe);
    for (int i = 0; i < 3; i++) begin
      logic [7:0] exp = memFn(a);
      sendBits(16'h0, 8, rx, oe);
      check(rx[7:0] == exp, "R5 read wrap data", rx[7:0], exp);
      check(oe == 1, "R1 read drives output", oe, 1);
      a = a + 1'b1;
    end
    csHigh();
    check(misoOe == 0, "R11 oe off after cs", misoOe, 0);
  endtask

  task automatic t_readHold();
    logic [15:0] rx; logic [15:0] rx2; logic oe, oeH;
    logic [7:0] got;
    csLow(); sendBits(16'h03, 8, rx, oe); sendBits(16'h01, 8, rx, oe);
    sendBits(16'h2, 4, rx, oe);
    holdPause(3, oeH);
    sendBits(16'h3, 4, rx, oe);
    sendBits(16'h0, 3, rx, oe);
    holdPause(4, oeH);
    check(oeH == 0, "R6 output off in hold", oeH, 0);
    sendBits(16'h0, 5, rx2, oe);
    got = {rx[2:0], rx2[4:0]};
    check(got == memFn(11'h123), "R6 resume after hold", got, memFn(11'h123));
    check(oe == 1, "R6 output back after release", oe, 1);
    sendBits(16'h0, 8, rx, oe);
    check(rx[7:0] == memFn(11'h124), "R5 increment after hold", rx[7:0], memFn(11'h124));
    csHigh();
  endtask

  task automatic t_holdHighIgnored();
    logic [15:0] rx; logic oe;
    csLow(); sendBits(16'h0, 3, rx, oe);
    holdN = 0; waitH();
    sendBits(16'h06, 5, rx, oe);
    holdN = 1; csHigh();
    check(wrenCnt == 3, "R6 hold fall with sck high ignored", wrenCnt, 3);
  endtask

  task automatic t_write();
    logic [15:0] rx; logic oe;
    csLow(); sendBits(16'h02, 8, rx, oe); sendBits(16'hF845, 16, rx, oe);
    sendBits(16'h3C, 8, rx, oe); sendBits(16'hC3, 8, rx, oe); csHigh();
    check(byteCnt == 2 && lastByte == 8'hC3, "R8 data bytes", lastByte, 8'hC3);
    check(cmdAddr == 11'h045, "R8 write address low bits", cmdAddr, 11'h045);
    check(commitCnt == 1 && lastSt == 0 && cancelCnt == 0, "R8 commit on boundary", commitCnt, 1);
    csLow(); sendBits(16'h02, 8, rx, oe); sendBits(16'hF9AB, 16, rx, oe);
    sendBits(16'h11, 8, rx, oe); sendBits(16'h5, 3, rx, oe); csHigh();
    check(cancelCnt == 1 && commitCnt == 1, "R8 cancel mid byte", cancelCnt, 1);
    csLow(); sendBits(16'h02, 8, rx, oe); sendBits(16'h0010, 16, rx, oe); csHigh();
    check(cancelCnt == 2 && commitCnt == 1, "R8 cancel without data", cancelCnt, 2);
  endtask

  task automatic t_wrsr();
    logic [15:0] rx; logic oe;
    csLow(); sendBits(16'h01, 8, rx, oe); sendBits(16'h0C, 8, rx, oe); csHigh();
    check(commitCnt == 2 && lastSt == 1 && lastByte == 8'h0C, "R9 status commit", commitCnt, 2);
    csLow(); sendBits(16'h01, 8, rx, oe); sendBits(16'h0C0C, 16, rx, oe); csHigh();
    check(commitCnt == 2 && cancelCnt == 3, "R9 two bytes cancel", cancelCnt, 3);
  endtask

  task automatic t_holdAbort();
    logic [15:0] rx; logic oe, oeH;
    csLow(); sendBits(16'h02, 8, rx, oe); sendBits(16'h0010, 16, rx, oe);
    sendBits(16'hAA, 8, rx, oe);
    holdPause(0, oeH);
    holdN = 0; waitH(); waitH();
    csN = 1; waitH(); waitH(); holdN = 1; waitH();
    check(cancelCnt == 4 && commitCnt == 2, "R7 cs rise in hold cancels", cancelCnt, 4);
    csLow(); sendBits(16'h06, 8, rx, oe); csHigh();
    check(wrenCnt == 4, "R7 fresh frame after abort", wrenCnt, 4);
  endtask

  task automatic t_busy();
    logic [15:0] rx; logic oe;
    busy = 1; statusIn = 8'hA5;
    csLow(); sendBits(16'h06, 8, rx, oe); csHigh();
    check(wrenCnt == 4, "R10 wren ignored when busy", wrenCnt, 4);
    csLow(); sendBits(16'h03, 8, rx, oe); sendBits(16'h0000, 16, rx, oe);
    sendBits(16'h0, 8, rx, oe); csHigh();
    check(oe == 0, "R10 read ignored when busy", oe, 0);
    csLow(); sendBits(16'h05, 8, rx, oe); sendBits(16'h0, 16, rx, oe); csHigh();
    check(rx == 16'hA5A5 && oe == 1, "R12 status repeats while busy", rx, 16'hA5A5);
    busy = 0;
  endtask

  task automatic t_partial();
    logic [15:0] rx; logic oe;
    csLow(); sendBits(16'h7, 3, rx, oe); csHigh();
    csLow(); sendBits(16'h06, 8, rx, oe); csHigh();
    check(wrenCnt == 5, "R11 counters cleared by cs", wrenCnt, 5);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1;
    waitH();
    t_reset();
    t_wrenWrdi();
    t_mode3();
    t_unknown();
    t_readWrap();
    t_readHold();
    t_holdHighIgnored();
    t_write();
    t_wrsr();
    t_holdAbort();
    t_busy();
    t_partial();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      runCnt++; failCnt++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end
endmodule